// File: doc/BRIEF.md
# Frame schedule list walker

At every frame start this block traverses the periodic schedule a host controller keeps in system memory. The schedule is a singly linked structure made of queue heads (two words) and transfer descriptors (four words). From the frame list base and the low ten bits of the frame number the walker fetches the frame entry. It then follows link words one at a time over a 32-bit word master port. Each descriptor's control and token words go to a separate status updater. The walker then acts on the outcome the updater returns, and collects the interrupt-cause bits of every descriptor it visits.

Two bounds keep a corrupt or circular schedule from stalling the frame. One is a cap on link evaluations. The other is a table of queue-head links already entered during the walk. When a descriptor inside a queue head completes, the walker advances that queue head's element pointer in memory. Moving payload data and running bus transactions belong to other blocks.

Top module: `sched_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `done`, `mem_req_valid` and `upd_req_valid` are 0 and `int_mask` is 0.
- R2: A `start` pulse while idle issues a read of the frame entry at `fl_base + frame_num[9:0]*4`, and this is the first request of the walk.
- R3: A link word with bit 0 set ends the walk. If the frame entry itself has bit 0 set, the walk ends after that single read with `int_mask` 0 and no updater request.
- R4: A link with bit 0 clear and bit 1 set names a queue head at the link with its low four bits cleared (P). The walker reads P (horizontal link) and then P+4 (element link). If the element link has bit 0 set, the walk goes on at the horizontal link and no queue head is current. Otherwise that queue head becomes current and the walk goes on at the element link.
- R5: A link with bits 0 and 1 clear names a descriptor at P. The walker reads P, P+4 and P+8 (link, control, token) and presents control and token to the updater. It does not drive the memory port while that request is open.
- R6: The control word returned by the updater is written to P+4 only when it differs from the control word read.
- R7: Updater outcome code 2 (fatal) ends the walk. Codes 1 and 3 (skip) continue at the current queue head's horizontal link, or at the descriptor's link when no queue head is current.
- R8: Outcome code 0 (complete) continues at the descriptor's link. Inside a current queue head, that link is first written to the queue head's P+4. If the link has bit 2 clear, the queue head is left and the walk continues at its horizontal link.
- R9: No more than 100 link words are acted on per walk, so at most 100 descriptors reach the updater.
- R10: A queue-head link equal to one already entered in the same walk, or met when 128 are recorded, ends the walk.
- R11: At the end of the walk `done` is high for exactly one cycle. `int_mask` then shows the OR of all cause bits the updater returned during that walk and holds it until the next walk ends.
- R12: At most one read is outstanding. A request held without `mem_req_ready` keeps its address, direction and data.
- R13: A `start` pulse while a walk is in progress is ignored. The walk finishes exactly as if the pulse had not come.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame start pulse |
| frame_num | input | 11 | Current frame number |
| fl_base | input | 32 | Frame list base address |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| upd_req_valid | output | 1 | Descriptor presented to updater |
| upd_ctrl | output | 32 | Descriptor control word |
| upd_token | output | 32 | Descriptor token word |
| upd_resp_valid | input | 1 | Updater response valid |
| upd_resp_ctrl | input | 32 | Updated control word |
| upd_resp_outcome | input | 2 | 0 complete, 1/3 skip, 2 fatal |
| upd_resp_cause | input | 2 | Interrupt cause bits for this descriptor |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| int_mask | output | 2 | Accumulated cause mask of the last walk |

## Verification
Random schedules of mixed queue heads and descriptors are built with random loops and terminations. Each descriptor gets a random outcome, cause and control change. Outcomes are compared with a bench model through read count, updater count, cause mask and final memory image, so these walks separate the skip, complete and fatal paths and the element write-back. Directed schedules isolate a terminating frame entry, a 150-descriptor chain that only the 100-step cap can stop, a self-linked queue head that only loop detection can stop, and a queue head whose depth-first chain shows the element pointer advancing and then leaving. Extra `start` pulses in the middle of random walks must leave every result unchanged, and random stalls on `mem_req_ready` exercise request holding.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int SW_AW = 32;
  localparam int SW_FNW = 11;
  localparam int SW_MW = 2;

  localparam logic [1:0] OC_DONE  = 2'd0;
  localparam logic [1:0] OC_FATAL = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_RD, S_WAIT, S_EVAL, S_UPD, S_WB_CTRL, S_POST, S_WB_ELEM, S_FIN
  } walk_st_e;

  typedef enum logic [2:0] {
    K_ENTRY, K_QH_H, K_QH_E, K_TD_L, K_TD_C, K_TD_T
  } rd_kind_e;

  function automatic logic lk_term(input logic [SW_AW-1:0] l);
    return l[0];
  endfunction

  function automatic logic lk_qh(input logic [SW_AW-1:0] l);
    return l[1];
  endfunction

  function automatic logic lk_depth(input logic [SW_AW-1:0] l);
    return l[2];
  endfunction

  function automatic logic [SW_AW-1:0] lk_ptr(input logic [SW_AW-1:0] l);
    return {l[SW_AW-1:4], 4'b0000};
  endfunction

  function automatic logic [SW_AW-1:0] entry_addr(input logic [SW_AW-1:0] base,
                                                  input logic [SW_FNW-1:0] fn);
    return base + {{(SW_AW-12){1'b0}}, fn[9:0], 2'b00};
  endfunction
endpackage

// File: rtl/qh_visit_table.sv
module qh_visit_table #(
  parameter int DEPTH = 128,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ins,
  input  logic [AW-1:0] key,
  output logic          hit,
  output logic          full
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0]    ent [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [CW-1:0]    cnt;
  logic [IW-1:0]    idx;

  assign idx  = cnt[IW-1:0];
  assign full = (cnt == CW'(DEPTH));

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (vld[i] && ent[i] == key) hit = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      cnt <= '0;
    end else if (clr) begin
      vld <= '0;
      cnt <= '0;
    end else if (ins && !full) begin
      vld[idx] <= 1'b1;
      cnt      <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins && !full) ent[idx] <= key;
  end
endmodule

// File: rtl/walk_budget.sv
module walk_budget #(
  parameter int LIMIT = 100,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic          spent,
  output logic [CW-1:0] used
);
  assign spent = (used == CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             used <= '0;
    else if (clr)           used <= '0;
    else if (step && !spent) used <= used + 1'b1;
  end
endmodule

// File: rtl/sched_walker.sv
module sched_walker
  import sw_pkg::*;
#(
  parameter int MAX_STEPS = 100,
  parameter int QH_SLOTS  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SW_FNW-1:0] frame_num,
  input  logic [SW_AW-1:0]  fl_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [SW_AW-1:0]  mem_req_addr,
  output logic [SW_AW-1:0]  mem_req_wdata,
  input  logic              mem_rvalid,
  input  logic [SW_AW-1:0]  mem_rdata,
  output logic              upd_req_valid,
  output logic [SW_AW-1:0]  upd_ctrl,
  output logic [SW_AW-1:0]  upd_token,
  input  logic              upd_resp_valid,
  input  logic [SW_AW-1:0]  upd_resp_ctrl,
  input  logic [1:0]        upd_resp_outcome,
  input  logic [SW_MW-1:0]  upd_resp_cause,
  output logic              busy,
  output logic              done,
  output logic [SW_MW-1:0]  int_mask
);
  localparam int BW = $clog2(MAX_STEPS + 1);

  walk_st_e         st;
  rd_kind_e         kind;
  logic [SW_AW-1:0] link, rd_addr, qh_h, cur_qh, td_link, td_ctrl, td_tok, new_ctrl;
  logic             cur_v;
  logic [1:0]       oc;
  logic [SW_MW-1:0] acc, mask_q;
  logic             done_q;

  // Named events for the checker
  logic          rd_inflight, walk_end, eval_go, tbl_ins, loop_stop;
  logic          tbl_hit, tbl_full, spent;
  logic [BW-1:0] iter_used;

  assign rd_inflight = (st == S_WAIT);
  assign walk_end    = (st == S_FIN);
  assign eval_go     = (st == S_EVAL) && !lk_term(link) && !spent;
  assign loop_stop   = eval_go && lk_qh(link) && (tbl_hit || tbl_full);
  assign tbl_ins     = eval_go && lk_qh(link) && !tbl_hit && !tbl_full;

  qh_visit_table #(.DEPTH(QH_SLOTS), .AW(SW_AW)) u_tbl (
    .clk(clk), .rst_n(rst_n), .clr(st == S_IDLE), .ins(tbl_ins),
    .key(link), .hit(tbl_hit), .full(tbl_full)
  );

  walk_budget #(.LIMIT(MAX_STEPS)) u_budget (
    .clk(clk), .rst_n(rst_n), .clr(st == S_IDLE), .step(eval_go),
    .spent(spent), .used(iter_used)
  );

  always_comb begin
    mem_req_valid = (st == S_RD) || (st == S_WB_CTRL) || (st == S_WB_ELEM);
    mem_req_we    = (st == S_WB_CTRL) || (st == S_WB_ELEM);
    unique case (st)
      S_WB_CTRL: mem_req_addr = lk_ptr(link) + SW_AW'(4);
      S_WB_ELEM: mem_req_addr = lk_ptr(cur_qh) + SW_AW'(4);
      default:   mem_req_addr = rd_addr;
    endcase
    mem_req_wdata = (st == S_WB_CTRL) ? new_ctrl : td_link;
  end

  assign upd_req_valid = (st == S_UPD);
  assign upd_ctrl      = td_ctrl;
  assign upd_token     = td_tok;
  assign busy          = (st != S_IDLE);
  assign done          = done_q;
  assign int_mask      = mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;      kind <= K_ENTRY;
      link <= '0;        rd_addr <= '0;   qh_h <= '0;    cur_qh <= '0;
      td_link <= '0;     td_ctrl <= '0;   td_tok <= '0;  new_ctrl <= '0;
      cur_v <= 1'b0;     oc <= '0;        acc <= '0;     mask_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          rd_addr <= entry_addr(fl_base, frame_num);
          kind    <= K_ENTRY;
          cur_v   <= 1'b0;
          acc     <= '0;
          st      <= S_RD;
        end
        S_RD: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          st      <= S_RD;
          rd_addr <= rd_addr + SW_AW'(4);
          unique case (kind)
            K_ENTRY: begin link <= mem_rdata; st <= S_EVAL; end
            K_QH_H:  begin qh_h <= mem_rdata; kind <= K_QH_E; end
            K_QH_E: begin
              st <= S_EVAL;
              if (lk_term(mem_rdata)) begin
                cur_v <= 1'b0;
                link  <= qh_h;
              end else begin
                cur_v  <= 1'b1;
                cur_qh <= link;
                link   <= mem_rdata;
              end
            end
            K_TD_L:  begin td_link <= mem_rdata; kind <= K_TD_C; end
            K_TD_C:  begin td_ctrl <= mem_rdata; kind <= K_TD_T; end
            K_TD_T:  begin td_tok  <= mem_rdata; st <= S_UPD; end
            default: st <= S_FIN;
          endcase
        end
        S_EVAL: begin
          if (!eval_go || loop_stop) st <= S_FIN;
          else begin
            rd_addr <= lk_ptr(link);
            kind    <= lk_qh(link) ? K_QH_H : K_TD_L;
            st      <= S_RD;
          end
        end
        S_UPD: if (upd_resp_valid) begin
          acc      <= acc | upd_resp_cause;
          new_ctrl <= upd_resp_ctrl;
          oc       <= upd_resp_outcome;
          st       <= (upd_resp_ctrl != td_ctrl) ? S_WB_CTRL : S_POST;
        end
        S_WB_CTRL: if (mem_req_ready) st <= S_POST;
        S_POST: begin
          if (oc == OC_FATAL) st <= S_FIN;
          else if (oc != OC_DONE) begin
            link <= cur_v ? qh_h : td_link;
            st   <= S_EVAL;
          end else if (cur_v) st <= S_WB_ELEM;
          else begin
            link <= td_link;
            st   <= S_EVAL;
          end
        end
        S_WB_ELEM: if (mem_req_ready) begin
          st <= S_EVAL;
          if (lk_depth(td_link)) link <= td_link;
          else begin
            cur_v <= 1'b0;
            link  <= qh_h;
          end
        end
        S_FIN: begin
          done_q <= 1'b1;
          mask_q <= acc;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sched_walker_chk.sv
module sched_walker_chk #(
  parameter int LIMIT = 100,
  parameter int BW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [31:0]   mem_req_addr,
  input logic [31:0]   mem_req_wdata,
  input logic          upd_req_valid,
  input logic          rd_inflight,
  input logic          walk_end,
  input logic          loop_stop,
  input logic [BW-1:0] iter_used
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata)); // R12
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_inflight |-> !mem_req_valid); // R12
  AST_UPD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req_valid |-> !mem_req_valid); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    walk_end |=> done && !busy); // R11
  AST_LOOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    loop_stop |=> walk_end); // R10
  AST_STEP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    iter_used <= BW'(LIMIT)); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !walk_end |=> busy); // R13
endmodule

bind sched_walker sched_walker_chk #(.LIMIT(MAX_STEPS), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .upd_req_valid(upd_req_valid),
  .rd_inflight(rd_inflight), .walk_end(walk_end), .loop_stop(loop_stop),
  .iter_used(iter_used)
);

// File: tb/sim_sched_walker.sv
module sim_sched_walker;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [10:0] frame_num = '0;
  logic [31:0] fl_base = '0;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic upd_req_valid;
  logic [31:0] upd_ctrl, upd_token;
  logic upd_resp_valid = 1'b0;
  logic [31:0] upd_resp_ctrl = '0;
  logic [1:0] upd_resp_outcome = '0, upd_resp_cause = '0;
  logic busy, done;
  logic [1:0] int_mask;

  sched_walker u0 (.*);

  always #10 clk = ~clk;   // 50 MHz

  int n_tests = 0, n_fail = 0, cyc = 0;
  logic [31:0] mem [int unsigned];
  logic [31:0] ref_mem [int unsigned];

  // bus model counters
  int n_rd, n_wr, n_upd, hold_err;
  logic first_rd, rd_pend, prev_stall;
  logic [31:0] first_addr, rd_pend_addr, prev_addr;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mrd(input int unsigned a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction
  function automatic logic [31:0] rrd(input int unsigned a);
    return ref_mem.exists(a) ? ref_mem[a] : 32'h0;
  endfunction

  // updater behaviour: outcome = token[1:0], flip ctrl bit 23 when token[4], cause = token[6:5]
  function automatic logic [31:0] upd_new(input logic [31:0] c, input logic [31:0] t);
    return t[4] ? (c ^ 32'h0080_0000) : c;
  endfunction

  always @(negedge clk) begin
    cyc++;
    mem_rvalid = 1'b0;
    if (rd_pend) begin
      mem_rvalid = 1'b1;
      mem_rdata  = mrd(rd_pend_addr);
      rd_pend    = 1'b0;
    end
    if (prev_stall && !(mem_req_valid && mem_req_addr == prev_addr)) hold_err++;
    mem_req_ready = ($urandom_range(3) != 0);
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem[mem_req_addr] = mem_req_wdata;
        n_wr++;
      end else begin
        rd_pend = 1'b1;
        rd_pend_addr = mem_req_addr;
        n_rd++;
        if (first_rd) begin first_addr = mem_req_addr; first_rd = 1'b0; end
      end
    end
    prev_stall = mem_req_valid && !mem_req_ready;
    prev_addr  = mem_req_addr;
    upd_resp_valid = 1'b0;
    if (upd_req_valid) begin
      upd_resp_valid   = 1'b1;
      upd_resp_ctrl    = upd_new(upd_ctrl, upd_token);
      upd_resp_outcome = upd_token[1:0];
      upd_resp_cause   = upd_token[6:5];
      n_upd++;
    end
  end

  // bench model of one walk over ref_mem
  task automatic ref_walk(input logic [31:0] base, input logic [10:0] fn,
                          output logic [1:0] emask, output int ereads, output int eupd);
    logic [31:0] link, qh_h, cur_qh, p, tl, c, t, nc, qe;
    logic cur_v;
    int steps;
    int unsigned vis[$];
    logic seen;
    emask = 0; ereads = 1; eupd = 0; steps = 0; cur_v = 0; qh_h = 0; cur_qh = 0;
    link = rrd(base + {fn[9:0], 2'b00});
    forever begin
      if (link[0] || steps == 100) break;
      steps++;
      p = {link[31:4], 4'h0};
      if (link[1]) begin
        seen = 0;
        foreach (vis[i]) if (vis[i] == link) seen = 1;
        if (seen || vis.size() >= 128) break;
        vis.push_back(link);
        qh_h = rrd(p); qe = rrd(p + 4); ereads += 2;
        if (qe[0]) begin cur_v = 0; link = qh_h; end
        else begin cur_v = 1; cur_qh = link; link = qe; end
      end else begin
        tl = rrd(p); c = rrd(p + 4); t = rrd(p + 8); ereads += 3; eupd++;
        nc = upd_new(c, t);
        emask |= t[6:5];
        if (nc != c) ref_mem[p + 4] = nc;
        if (t[1:0] == 2'd2) break;
        if (t[1:0] != 2'd0) link = cur_v ? qh_h : tl;
        else if (cur_v) begin
          ref_mem[{cur_qh[31:4], 4'h0} + 4] = tl;
          if (tl[2]) link = tl;
          else begin cur_v = 0; link = qh_h; end
        end else link = tl;
      end
    end
  endtask

  task automatic run_walk(input logic [31:0] base, input logic [10:0] fn,
                          input string tag, input logic inject);
    logic [1:0] emask;
    int ereads, eupd, w, bad;
    ref_mem = mem;
    ref_walk(base, fn, emask, ereads, eupd);
    n_rd = 0; n_wr = 0; n_upd = 0; first_rd = 1'b1;
    @(negedge clk); start = 1'b1; frame_num = fn; fl_base = base;
    @(negedge clk); start = 1'b0;
    if (inject && ereads > 4) begin
      repeat (2) @(negedge clk);
      chk(busy == 1'b1, "R13", {31'b0, busy}, 32'h1);
      start = 1'b1; frame_num = fn ^ 11'h155; fl_base = base ^ 32'h0001_0000;  // R13 pulse while busy
      @(negedge clk); start = 1'b0;
    end
    w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    chk(done == 1'b1, "R11", {31'b0, done}, 32'h1);
    chk(int_mask == emask, "R11", {30'b0, int_mask}, {30'b0, emask});
    chk(n_rd == ereads, tag, n_rd, ereads);
    chk(n_upd == eupd, "R5", n_upd, eupd);
    chk(first_addr == base + {fn[9:0], 2'b00}, "R2", first_addr, base + {fn[9:0], 2'b00});
    bad = 0;
    foreach (ref_mem[k]) if (!mem.exists(k) || mem[k] != ref_mem[k]) bad++;
    if (mem.size() != ref_mem.size()) bad++;
    chk(bad == 0, "R8", bad, 0);
    @(negedge clk);
    chk(done == 1'b0 && int_mask == emask, "R11", {30'b0, int_mask}, {30'b0, emask});
  endtask

  function automatic logic [31:0] node_addr(input int j);
    return 32'h0000_4000 + j * 16;
  endfunction

  logic is_qh [24];

  function automatic logic [31:0] mk_link();
    int j;
    if ($urandom_range(5) == 0) return 32'h1 | ($urandom_range(7) << 1);
    j = $urandom_range(23);
    return node_addr(j) | (is_qh[j] ? 32'h2 : 32'h0) | ($urandom_range(1) ? 32'h4 : 32'h0);
  endfunction

  function automatic logic [31:0] mk_tok();
    logic [31:0] t;
    int r;
    t = $urandom;
    r = $urandom_range(9);
    t[1:0] = (r < 6) ? 2'd0 : (r < 8) ? 2'd1 : (r == 8) ? 2'd3 : 2'd2;
    return t;
  endfunction

  task automatic build_random(output logic [31:0] base, output logic [10:0] fn);
    logic [31:0] e;
    mem.delete();
    for (int j = 0; j < 24; j++) is_qh[j] = ($urandom_range(2) == 0);
    for (int j = 0; j < 24; j++) begin
      if (is_qh[j]) begin
        mem[node_addr(j)] = mk_link();
        e = mk_link();
        if ($urandom_range(2) == 0) e = 32'h1;
        mem[node_addr(j) + 4] = e;
      end else begin
        mem[node_addr(j)]      = mk_link();
        mem[node_addr(j) + 4]  = $urandom;
        mem[node_addr(j) + 8]  = mk_tok();
        mem[node_addr(j) + 12] = $urandom;
      end
    end
    base = $urandom_range(1) ? 32'h0002_0000 : 32'h0003_0000;
    fn = 11'($urandom);
    e = mk_link();
    if (e[0]) e = node_addr(0) | (is_qh[0] ? 32'h2 : 32'h0);
    mem[base + {fn[9:0], 2'b00}] = e;
  endtask

  initial begin
    logic [31:0] b;
    logic [10:0] f;
    void'($urandom(32'd20240611));
    rd_pend = 0; prev_stall = 0; hold_err = 0; first_rd = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !mem_req_valid && !upd_req_valid && int_mask == 0, "R1",
        {busy, done, mem_req_valid, upd_req_valid, 26'b0, int_mask}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !mem_req_valid, "R1", {31'b0, busy}, 32'h0);

    // R3: terminating frame entry
    mem.delete();
    mem[32'h0001_0000 + 12'h7fc] = 32'h0000_4003;
    run_walk(32'h0001_0000, 11'h5ff, "R3", 1'b0);
    chk(n_rd == 1 && n_upd == 0, "R3", n_rd, 1);

    // R9: 150 skipping descriptors in a chain
    mem.delete();
    for (int i = 0; i < 150; i++) begin
      mem[32'h8000 + i * 16]     = 32'h8000 + (i + 1) * 16;
      mem[32'h8000 + i * 16 + 4] = 32'h0;
      mem[32'h8000 + i * 16 + 8] = 32'h21;   // skip, cause 1
    end
    mem[32'h0002_0000] = 32'h8000;
    run_walk(32'h0002_0000, 11'h400, "R9", 1'b0);
    chk(n_upd == 100, "R9", n_upd, 100);

    // R10: self-linked queue head with empty element
    mem.delete();
    mem[32'h9000] = 32'h9002; mem[32'h9004] = 32'h1;
    mem[32'h0002_0000] = 32'h9002;
    run_walk(32'h0002_0000, 11'h000, "R10", 1'b0);
    chk(n_rd == 3, "R10", n_rd, 3);

    // R8 / R6: queue head with depth-first chain, then leaving it
    mem.delete();
    mem[32'hA000] = 32'h1; mem[32'hA004] = 32'hA100;
    mem[32'hA100] = 32'hA114; mem[32'hA104] = 32'h5; mem[32'hA108] = 32'h20;  // complete, cause 1
    mem[32'hA110] = 32'hA120; mem[32'hA114] = 32'h7; mem[32'hA118] = 32'h50;  // complete, cause 2, ctrl flip
    mem[32'hA120] = 32'h1;    mem[32'hA124] = 32'h0; mem[32'hA128] = 32'h0;
    mem[32'h0002_0008] = 32'hA002;
    run_walk(32'h0002_0000, 11'h002, "R4", 1'b0);
    chk(mem[32'hA004] == 32'hA120, "R8", mem[32'hA004], 32'hA120);
    chk(int_mask == 2'b11, "R11", {30'b0, int_mask}, 32'h3);
    chk(mem[32'hA104] == 32'h5 && mem[32'hA114] == 32'h0080_0007, "R6", mem[32'hA114], 32'h0080_0007);
    chk(n_wr == 3, "R6", n_wr, 3);

    // R7: fatal descriptor stops before the next
    mem.delete();
    mem[32'hB000] = 32'hB010; mem[32'hB004] = 32'h0; mem[32'hB008] = 32'h2;
    mem[32'hB010] = 32'h1;    mem[32'hB014] = 32'h0; mem[32'hB018] = 32'h0;
    mem[32'h0002_0000] = 32'hB000;
    run_walk(32'h0002_0000, 11'h000, "R7", 1'b0);
    chk(n_upd == 1 && n_wr == 0, "R7", n_upd, 1);

    // random schedules
    for (int k = 0; k < 40; k++) begin
      build_random(b, f);
      run_walk(b, f, "R4", (k % 3) == 0);
    end
    chk(hold_err == 0, "R12", hold_err, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 190000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule